// File: doc/BRIEF.md
# Processor Idle Clock-Gating Controller

This block takes a processor domain into a low-power idle state and brings it back out by switching clock enables in a fixed order. An idle request comes from the core's wait-for-interrupt instruction. The block passes that request to the interrupt handler and waits for an acknowledge while no interrupt is pending. It then stops the core clock. It waits for the core to report standby, and only after that gates the peripheral clocks that software marked to idle together with the processor. A pending interrupt seen while idle starts the wake sequence. The peripheral clocks come back first and the core clock comes back one cycle later.

Software sets the peripheral clocks through two write-only registers, each with one bit per peripheral. The direct-enable register switches a clock on or off while the processor runs. The idle-follow register names the clocks to gate during idle. The LCD clock never follows idle. The watchdog timer clock stays on whenever the timer is in watchdog mode. Each enable is registered on the falling clock edge, so it cannot change while the gated clock is high.

Top module: `idle_clock_gater`

## Requirements
- R1: Under reset, whether applied at start-up or asynchronously during idle, `coreClkEn` and every bit of `periphClkEn` are 1, and `idleReq` and `idleStatus` are 0.
- R2: When `wfiReq` is 1 in the running state, `idleReq` is 1 after the next rising edge and the core clock stays enabled.
- R3: When `handlerAck` is 1 and `irqPending` is 0 while `idleReq` is 1, `coreClkEn` goes to 0 after the next edge pair. The peripheral enables do not change at that step.
- R4: When `irqPending` is 1 while `idleReq` is 1, idle entry is abandoned, even if `handlerAck` is also 1. `idleReq` returns to 0 and the core clock stays on.
- R5: The core stays stopped until `coreStandby` is 1. The next step gates the idle-follow peripherals, and the step after that raises `idleStatus`.
- R6: Peripheral bit 1 (LCD) is never gated by its idle-follow bit. Idle-follow bits have no effect while the processor runs.
- R7: While running, a write with `regSel`=0 drives each `periphClkEn` bit to the written value in the same cycle the write is taken.
- R8: While `wdtMode` is 1, bit 3 (watchdog timer) of `periphClkEn` is 1 whatever its direct-enable bit and idle-follow bit hold.
- R9: When `irqPending` is 1 during idle, the peripheral clocks are restored one step before the core clock, and `idleStatus` drops.
- R10: Register writes taken from the standby step until wake-up completes are stored. They act on the enables only once the running state is reached again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wfiReq | input | 1 | Idle request from a wait-for-interrupt instruction |
| handlerAck | input | 1 | Interrupt handler acknowledges the idle request |
| irqPending | input | 1 | Interrupt pending; aborts idle entry and wakes from idle |
| coreStandby | input | 1 | Core reports its internal clocks stopped |
| wdtMode | input | 1 | Timer configured as watchdog |
| regWe | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = direct-enable register, 1 = idle-follow register |
| regWdata | input | NUM_PERIPH | Write data, one bit per peripheral (0 timer, 1 LCD, 2 external, 3 watchdog timer) |
| idleReq | output | 1 | Idle request forwarded to the interrupt handler |
| idleStatus | output | 1 | Domain fully idle |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | NUM_PERIPH | Peripheral clock enables |

## Verification
The hardest case to reach is a register change made while the domain is idle. The bench must show that the change is held back, and then that it appears only when the core clock returns. The vector table leads the block through the full handshake: request, acknowledge, standby, then idle. It writes the direct-enable register while idle and checks that the enables stay frozen through the wake step. It then checks that the new value appears on the first running cycle. A second pass drops watchdog mode while idle, which shows that the idle-follow gating takes over from the forced enable.

// File: rtl/idle_gate_pkg.sv
package idle_gate_pkg;

  typedef enum logic [2:0] {
    ST_RUN         = 3'd0,
    ST_REQ_ACK     = 3'd1,
    ST_CORE_STOP   = 3'd2,
    ST_DOMAIN_STOP = 3'd3,
    ST_IDLE        = 3'd4,
    ST_WAKE        = 3'd5
  } idleStateE;

  // strobes from control to datapath
  typedef struct packed {
    logic applyCfg;    // live register values drive the enables
    logic coreStop;    // core clock held off
    logic domainStop;  // idle-follow peripherals gated
  } gateStrobeS;

endpackage

// File: rtl/idle_gate_ctrl.sv
module idle_gate_ctrl
  import idle_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wfiReq,
  input  logic       handlerAck,
  input  logic       irqPending,
  input  logic       coreStandby,
  output gateStrobeS strb,
  output logic       idleReq,
  output logic       idleStatus
);

  idleStateE state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:         if (wfiReq) stateNext = ST_REQ_ACK;
      ST_REQ_ACK: begin
        if (irqPending)      stateNext = ST_RUN;
        else if (handlerAck) stateNext = ST_CORE_STOP;
      end
      ST_CORE_STOP:   if (coreStandby) stateNext = ST_DOMAIN_STOP;
      ST_DOMAIN_STOP: stateNext = ST_IDLE;
      ST_IDLE:        if (irqPending) stateNext = ST_WAKE;
      ST_WAKE:        stateNext = ST_RUN;
      default:        stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  always_comb begin
    strb.applyCfg   = (state == ST_RUN) || (state == ST_REQ_ACK) || (state == ST_CORE_STOP);
    strb.coreStop   = (state == ST_CORE_STOP) || (state == ST_DOMAIN_STOP) ||
                      (state == ST_IDLE) || (state == ST_WAKE);
    strb.domainStop = (state == ST_DOMAIN_STOP) || (state == ST_IDLE);
    idleReq         = (state == ST_REQ_ACK);
    idleStatus      = (state == ST_IDLE);
  end

  assert_wfi_enter_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && wfiReq) |=> (state == ST_REQ_ACK));

  assert_ack_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ_ACK && handlerAck && !irqPending) |=> (state == ST_CORE_STOP));

  assert_pending_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REQ_ACK && irqPending) |=> (state == ST_RUN));

  assert_standby_wait_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CORE_STOP && !coreStandby) |=> (state == ST_CORE_STOP));

  assert_wake_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && irqPending) |=> (state == ST_WAKE));

endmodule

// File: rtl/idle_gate_cell.sv
module idle_gate_cell #(
  parameter bit AUTO_OK  = 1'b1,
  parameter bit FORCE_OK = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic immBit,
  input  logic autoBit,
  input  logic domainStop,
  input  logic forceOn,
  output logic clkEn
);

  logic idleGate, enNext;

  always_comb begin
    idleGate = AUTO_OK && autoBit && domainStop;
    enNext   = (immBit && !idleGate) || (FORCE_OK && forceOn);
  end

  // enable only moves while the gated clock is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) clkEn <= 1'b1;
    else       clkEn <= enNext;
  end

endmodule

// File: rtl/idle_gate_datapath.sv
module idle_gate_datapath
  import idle_gate_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int LCD_IDX    = 1,
  parameter int WDT_IDX    = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateStrobeS            strb,
  input  logic                  wdtMode,
  input  logic                  regWe,
  input  logic                  regSel,
  input  logic [NUM_PERIPH-1:0] regWdata,
  output logic                  coreClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn
);

  localparam logic [NUM_PERIPH-1:0] IMM_RESET  = {NUM_PERIPH{1'b1}};
  localparam logic [NUM_PERIPH-1:0] AUTO_RESET = {NUM_PERIPH{1'b0}};

  logic [NUM_PERIPH-1:0] immReg, autoReg;
  logic [NUM_PERIPH-1:0] frozenImm, frozenAuto;
  logic [NUM_PERIPH-1:0] effImm, effAuto;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      immReg  <= IMM_RESET;
      autoReg <= AUTO_RESET;
    end else if (regWe) begin
      if (regSel) autoReg <= regWdata;
      else        immReg  <= regWdata;
    end
  end

  // snapshot held while the domain is stopping, idle or waking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frozenImm  <= IMM_RESET;
      frozenAuto <= AUTO_RESET;
    end else if (strb.applyCfg) begin
      frozenImm  <= immReg;
      frozenAuto <= autoReg;
    end
  end

  always_comb begin
    effImm  = strb.applyCfg ? immReg  : frozenImm;
    effAuto = strb.applyCfg ? autoReg : frozenAuto;
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) coreClkEn <= 1'b1;
    else       coreClkEn <= !strb.coreStop;
  end

  for (genvar i = 0; i < NUM_PERIPH; i++) begin : gCell
    idle_gate_cell #(
      .AUTO_OK  (i != LCD_IDX),
      .FORCE_OK (i == WDT_IDX)
    ) u_cell (
      .clk        (clk),
      .rstN       (rstN),
      .immBit     (effImm[i]),
      .autoBit    (effAuto[i]),
      .domainStop (strb.domainStop),
      .forceOn    (wdtMode),
      .clkEn      (periphClkEn[i])
    );

    if (i != WDT_IDX) begin : gDirectChk
      assert_direct_off_R7: assert property (@(negedge clk) disable iff (!rstN)
        (strb.applyCfg && !immReg[i]) |=> !periphClkEn[i]);
    end
  end

  assert_lcd_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.domainStop && frozenImm[LCD_IDX]) |-> periphClkEn[LCD_IDX]);

  assert_wdt_forced_R8: assert property (@(negedge clk) disable iff (!rstN)
    wdtMode |=> periphClkEn[WDT_IDX]);

  assert_core_first_R5: assert property (@(negedge clk) disable iff (!rstN)
    strb.domainStop |=> !coreClkEn);

endmodule

// File: rtl/idle_clock_gater.sv
module idle_clock_gater
  import idle_gate_pkg::*;
#(
  parameter int NUM_PERIPH = 4,
  parameter int LCD_IDX    = 1,
  parameter int WDT_IDX    = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wfiReq,
  input  logic                  handlerAck,
  input  logic                  irqPending,
  input  logic                  coreStandby,
  input  logic                  wdtMode,
  input  logic                  regWe,
  input  logic                  regSel,
  input  logic [NUM_PERIPH-1:0] regWdata,
  output logic                  idleReq,
  output logic                  idleStatus,
  output logic                  coreClkEn,
  output logic [NUM_PERIPH-1:0] periphClkEn
);

  gateStrobeS strb;

  idle_gate_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wfiReq      (wfiReq),
    .handlerAck  (handlerAck),
    .irqPending  (irqPending),
    .coreStandby (coreStandby),
    .strb        (strb),
    .idleReq     (idleReq),
    .idleStatus  (idleStatus)
  );

  idle_gate_datapath #(
    .NUM_PERIPH (NUM_PERIPH),
    .LCD_IDX    (LCD_IDX),
    .WDT_IDX    (WDT_IDX)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wdtMode     (wdtMode),
    .regWe       (regWe),
    .regSel      (regSel),
    .regWdata    (regWdata),
    .coreClkEn   (coreClkEn),
    .periphClkEn (periphClkEn)
  );

endmodule

// File: tb/idle_clock_gater_tb.sv
`timescale 1ns/1ps
module idle_clock_gater_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       wfiReq, handlerAck, irqPending, coreStandby, wdtMode;
  logic       regWe, regSel;
  logic [3:0] regWdata;
  logic       idleReq, idleStatus, coreClkEn;
  logic [3:0] periphClkEn;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  idle_clock_gater u_dut (
    .clk(clk), .rstN(rstN), .wfiReq(wfiReq), .handlerAck(handlerAck),
    .irqPending(irqPending), .coreStandby(coreStandby), .wdtMode(wdtMode),
    .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .idleReq(idleReq), .idleStatus(idleStatus), .coreClkEn(coreClkEn),
    .periphClkEn(periphClkEn)
  );

  // {req[3:0], wfi ack pend stby wdtm we sel data[3:0], exp: req stat core en[3:0]}
  // peripheral bits: 3 watchdog timer, 2 external, 1 LCD, 0 timer
  localparam int NUM_VEC = 33;
  localparam logic [21:0] VECS [NUM_VEC] = '{
    {4'd1,  11'b0_0_0_0_0_0_0_0000, 7'b0_0_1_1111}, // R1 steady after reset
    {4'd7,  11'b0_0_0_0_0_1_0_1010, 7'b0_0_1_1010}, // R7 direct off
    {4'd7,  11'b0_0_0_0_0_1_0_1111, 7'b0_0_1_1111}, // R7 direct on
    {4'd6,  11'b0_0_0_0_0_1_1_1111, 7'b0_0_1_1111}, // R6 follow bits idle while running
    {4'd2,  11'b1_0_0_0_0_0_0_0000, 7'b1_0_1_1111}, // R2 request
    {4'd4,  11'b0_0_1_0_0_0_0_0000, 7'b0_0_1_1111}, // R4 abort
    {4'd2,  11'b1_0_0_0_0_0_0_0000, 7'b1_0_1_1111}, // R2 request again
    {4'd3,  11'b0_1_0_0_0_0_0_0000, 7'b0_0_0_1111}, // R3 core stops
    {4'd5,  11'b0_0_0_0_0_0_0_0000, 7'b0_0_0_1111}, // R5 waits for standby
    {4'd5,  11'b0_0_0_1_0_0_0_0000, 7'b0_0_0_0010}, // R5 domain gated, LCD kept
    {4'd5,  11'b0_0_0_1_0_0_0_0000, 7'b0_1_0_0010}, // R5 idle status
    {4'd10, 11'b0_0_0_1_0_1_0_0000, 7'b0_1_0_0010}, // R10 write held in idle
    {4'd9,  11'b0_0_1_1_0_0_0_0000, 7'b0_0_0_1111}, // R9 peripherals back first
    {4'd10, 11'b0_0_0_0_0_0_0_0000, 7'b0_0_1_0000}, // R10 held write applied
    {4'd7,  11'b0_0_0_0_0_1_0_1111, 7'b0_0_1_1111}, // R7
    {4'd8,  11'b0_0_0_0_1_1_0_0111, 7'b0_0_1_1111}, // R8 forced despite direct bit
    {4'd8,  11'b1_0_0_0_1_0_0_0000, 7'b1_0_1_1111}, // R8
    {4'd8,  11'b0_1_0_0_1_0_0_0000, 7'b0_0_0_1111}, // R8
    {4'd8,  11'b0_0_0_1_1_0_0_0000, 7'b0_0_0_1010}, // R8 forced despite follow bit
    {4'd8,  11'b0_0_0_1_1_0_0_0000, 7'b0_1_0_1010}, // R8
    {4'd8,  11'b0_0_0_1_0_0_0_0000, 7'b0_1_0_0010}, // R8 mode dropped
    {4'd9,  11'b0_0_1_1_0_0_0_0000, 7'b0_0_0_0111}, // R9 wake step
    {4'd9,  11'b0_0_0_0_0_0_0_0000, 7'b0_0_1_0111}, // R9 core last
    {4'd6,  11'b0_0_0_0_0_1_1_0000, 7'b0_0_1_0111}, // R6 follow bits cleared
    {4'd2,  11'b1_0_0_0_0_0_0_0000, 7'b1_0_1_0111}, // R2
    {4'd3,  11'b0_1_0_0_0_0_0_0000, 7'b0_0_0_0111}, // R3
    {4'd6,  11'b0_0_0_1_0_0_0_0000, 7'b0_0_0_0111}, // R6 nothing follows idle
    {4'd5,  11'b0_0_0_1_0_0_0_0000, 7'b0_1_0_0111}, // R5
    {4'd9,  11'b0_0_1_1_0_0_0_0000, 7'b0_0_0_0111}, // R9
    {4'd9,  11'b0_0_0_0_0_0_0_0000, 7'b0_0_1_0111}, // R9
    {4'd2,  11'b1_0_0_0_0_0_0_0000, 7'b1_0_1_0111}, // R2
    {4'd4,  11'b0_1_1_0_0_0_0_0000, 7'b0_0_1_0111}, // R4 pending beats ack
    {4'd4,  11'b0_0_0_0_0_0_0_0000, 7'b0_0_1_0111}  // R4 stays running
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic drive(input logic [10:0] v);
    {wfiReq, handlerAck, irqPending, coreStandby, wdtMode, regWe, regSel, regWdata} = v;
  endtask

  task automatic check(input int reqNo, input logic [6:0] exp, input string what);
    logic [6:0] act;
    act = {idleReq, idleStatus, coreClkEn, periphClkEn};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", reqNo, what, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(11'd0);
    repeat (3) tick();
    check(1, 7'b0_0_1_1111, "R1 reset state");
    rstN = 1'b1;

    for (int i = 0; i < NUM_VEC; i++) begin
      drive(VECS[i][17:7]);
      tick();
      check(int'(VECS[i][21:18]), VECS[i][6:0], $sformatf("vector %0d", i));
    end
    drive(11'd0);

    // R5 core stop held for several cycles without standby
    wfiReq = 1'b1; tick(); wfiReq = 1'b0;
    handlerAck = 1'b1; tick(); handlerAck = 1'b0;
    repeat (4) tick();
    check(5, 7'b0_0_0_0111, "R5 long standby wait");
    coreStandby = 1'b1; tick(); tick();
    check(5, 7'b0_1_0_0111, "R5 idle reached");

    // R1 asynchronous reset while idle
    rstN = 1'b0;
    #1;
    check(1, 7'b0_0_1_1111, "R1 reset during idle");
    coreStandby = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    check(1, 7'b0_0_1_1111, "R1 after reset release");

    // R7 timer off then on through the normal interface
    regWe = 1'b1; regSel = 1'b0; regWdata = 4'b1110; tick();
    check(7, 7'b0_0_1_1110, "R7 timer off");
    regWdata = 4'b1111; tick(); regWe = 1'b0;
    check(7, 7'b0_0_1_1111, "R7 timer on");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule